// File: doc/BRIEF.md
# Shared Two-Port GPIO Register Bank

This block holds the output-level and output-enable state for two groups of pins and lets two processor ports read and update that state through a small word-addressed register map. A wide user bank of 30 pins and a narrow 6-pin bank for a serial flash interface share one identical register layout. Each register that drives pins can be written whole, or changed in place by writing a mask to a set, clear or toggle alias, so that code on either port can change a few pins without a read-modify-write race.

Both ports may write or read in the same clock cycle, including the same register. Simultaneous updates are merged bitwise instead of one port winning outright, so changes to disjoint pins are never lost. Pad inputs pass through a two-flop synchronizer and can be read as a whole bank in one access; all read data returns one cycle after the request.

Top module: `gpio_dual_port`

## Requirements
- R1: While reset is low at a clock edge, every output-level and output-enable bit of both banks becomes 0 (all pins high impedance), and both read-data outputs become 0.
- R2: A write to the level register (word 0 of a bank) or the enable register (word 4) stores the low bank-width bits of the write data; upper data bits are ignored and read back as 0.
- R3: A write to a set alias (word 1 for level, word 5 for enable) makes the register bits that are 1 in the mask equal to 1 and leaves the others unchanged.
- R4: A write to a clear alias (word 2 for level, word 6 for enable) makes the register bits that are 1 in the mask equal to 0 and leaves the others unchanged.
- R5: A write to a toggle alias (word 3 for level, word 7 for enable) inverts the register bits that are 1 in the mask and leaves the others unchanged.
- R6: A read of any alias word returns 0; a read of an address that is misaligned, has byte address bit 7 set, or selects word 9 to 15 of a bank returns 0, and a write there changes no pin.
- R7: A read of the input word (word 8) returns every pad of the bank as seen through two synchronizer flops: a pad change applied before edge A is not seen by a read captured at edge A, and is seen by a read captured at edge A+2.
- R8: When both ports write the same register in one cycle, the base value is port 0's plain write if any, else port 1's plain write if any, else the current value; then the union of clear masks is applied, then the union of set masks, then the union of toggle masks.
- R9: Byte address bit 6 selects the bank (0 = 30-bit user bank, 1 = 6-bit flash bank); within the flash bank bit 0 is clock, bit 1 select, bits 2 to 5 data 0 to 3, and each bank's level and enable registers drive its own pin outputs directly.
- R10: Each port's read data, registered on the edge that captures its read request, reflects that port's own address, independent of a simultaneous access by the other port.
- R11: A read of a register in the same cycle as a write to it returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p0_wr_en | input | 1 | Port 0 write request |
| p0_rd_en | input | 1 | Port 0 read request |
| p0_addr | input | 8 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data or mask |
| p0_rdata | output | 32 | Port 0 read data, one cycle after request |
| p1_wr_en | input | 1 | Port 1 write request |
| p1_rd_en | input | 1 | Port 1 read request |
| p1_addr | input | 8 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data or mask |
| p1_rdata | output | 32 | Port 1 read data, one cycle after request |
| user_out | output | 30 | User bank output levels |
| user_oe | output | 30 | User bank output enables |
| user_in | input | 30 | User bank pad inputs |
| flash_out | output | 6 | Flash bank output levels |
| flash_oe | output | 6 | Flash bank output enables |
| flash_in | input | 6 | Flash bank pad inputs |

## Verification
The update logic is swept over every pairing of port operations (idle, plain write, set, clear, toggle) on both ports, for both the level and enable registers of both banks, each preceded by a fresh plain write of a different pseudo-random value. Single-port cases separate the four alias behaviours from each other, while the two-port cases show the clear-then-set-then-toggle order and the port 0 priority on plain writes, which a wrong order would break on overlapping masks. Walking-one pad patterns on both banks show bit order and the two-edge synchronizer delay, and same-cycle read-and-write pairs show that reads return the pre-write value.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants, register index encoding, decoded request type and
// the address decode function used by both ports.
// Assumes byte addressing with word-aligned registers; bit 6 picks the bank.
package gpio_bank_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int USER_W  = 30;
    localparam int FLASH_W = 6;
    localparam int IDX_W   = 4;
    localparam int LAST_IDX = 8;

    typedef enum logic [IDX_W-1:0] {
        RIDX_LVL     = 4'd0,
        RIDX_LVL_SET = 4'd1,
        RIDX_LVL_CLR = 4'd2,
        RIDX_LVL_TOG = 4'd3,
        RIDX_EN      = 4'd4,
        RIDX_EN_SET  = 4'd5,
        RIDX_EN_CLR  = 4'd6,
        RIDX_EN_TOG  = 4'd7,
        RIDX_PADS    = 4'd8
    } reg_idx_e;

    typedef struct packed {
        logic              wr_en;
        logic              rd_en;
        logic              hit;
        logic              bank;
        reg_idx_e          idx;
        logic [DATA_W-1:0] wdata;
    } port_req_t;

    // Turn a raw port access into a decoded request.
    function automatic port_req_t decode_access(
        input logic              wr,
        input logic              rd,
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] wdata
    );
        port_req_t r;
        r.wr_en = wr;
        r.rd_en = rd;
        r.bank  = addr[6];
        r.idx   = reg_idx_e'(addr[5:2]);
        r.hit   = (addr[7] == 1'b0) && (addr[1:0] == 2'b00)
                  && (addr[5:2] <= IDX_W'(LAST_IDX));
        r.wdata = wdata;
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of pad inputs.
// Assumes each bit is sampled independently; no multi-bit coherence is implied.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift pad values through two capture flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // R7: output equals the pad value two samples earlier once out of reset.
    a_r7_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_reg_update.sv
// One pin-driving register with merged updates from two ports.
// Assumes each port presents at most one of plain/set/clear/toggle per cycle;
// the caller ORs the per-port masks before they arrive here.
module gpio_reg_update #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr0,
    input  logic [W-1:0] wdata0,
    input  logic         wr1,
    input  logic [W-1:0] wdata1,
    input  logic [W-1:0] set_m,
    input  logic [W-1:0] clr_m,
    input  logic [W-1:0] tog_m,
    output logic [W-1:0] q
);
    logic [W-1:0] base;
    logic [W-1:0] nxt;

    // Pick the base value: port 0 plain write, then port 1, then hold.
    always_comb begin
        if (wr0)      base = wdata0;
        else if (wr1) base = wdata1;
        else          base = q;
    end

    // Apply clear, then set, then toggle on top of the base.
    always_comb nxt = ((base & ~clr_m) | set_m) ^ tog_m;

    // Register the merged value.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R6: with no update of any kind the register holds.
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr0 && !wr1 && set_m == '0 && clr_m == '0 && tog_m == '0) |=> $stable(q));

    // R3: set-only cycle forces masked bits high and keeps the rest.
    a_r3_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr0 && !wr1 && clr_m == '0 && tog_m == '0)
        |=> ((q & $past(set_m)) == $past(set_m))
            && ((q & ~$past(set_m)) == ($past(q) & ~$past(set_m))));

    // R4: clear without set or toggle leaves masked bits low.
    a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr0 && !wr1 && set_m == '0 && tog_m == '0)
        |=> ((q & $past(clr_m)) == '0));

    // R8: a lone port 0 plain write wins over port 1.
    a_r8_port0_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && set_m == '0 && clr_m == '0 && tog_m == '0) |=> (q == $past(wdata0)));

endmodule

// File: rtl/gpio_bank.sv
// One pin bank: level and enable registers with alias decode, pad synchronizer
// and combinational read selection for both ports.
// Assumes requests arrive already decoded; BANK_ID is compared to the bank bit.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int   W       = 8,
    parameter logic BANK_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_req_t         req0,
    input  port_req_t         req1,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [DATA_W-1:0] rd_val0,
    output logic [DATA_W-1:0] rd_val1
);
    localparam int NREG = 2;
    localparam int STRIDE = 4;

    logic         wsel0;
    logic         wsel1;
    logic [W-1:0] regs [NREG];
    logic [W-1:0] pads_sync;

    assign wsel0 = req0.wr_en && req0.hit && (req0.bank == BANK_ID);
    assign wsel1 = req1.wr_en && req1.hit && (req1.bank == BANK_ID);

    gpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pads_sync)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [IDX_W-1:0] BASE = IDX_W'(g * STRIDE);
        logic         pw0, pw1;
        logic [W-1:0] smask, cmask, tmask;

        // Build this register's plain-write strobes and merged alias masks.
        always_comb begin
            pw0   = wsel0 && (req0.idx == reg_idx_e'(BASE));
            pw1   = wsel1 && (req1.idx == reg_idx_e'(BASE));
            smask = ((wsel0 && req0.idx == reg_idx_e'(BASE + 4'd1)) ? req0.wdata[W-1:0] : '0)
                  | ((wsel1 && req1.idx == reg_idx_e'(BASE + 4'd1)) ? req1.wdata[W-1:0] : '0);
            cmask = ((wsel0 && req0.idx == reg_idx_e'(BASE + 4'd2)) ? req0.wdata[W-1:0] : '0)
                  | ((wsel1 && req1.idx == reg_idx_e'(BASE + 4'd2)) ? req1.wdata[W-1:0] : '0);
            tmask = ((wsel0 && req0.idx == reg_idx_e'(BASE + 4'd3)) ? req0.wdata[W-1:0] : '0)
                  | ((wsel1 && req1.idx == reg_idx_e'(BASE + 4'd3)) ? req1.wdata[W-1:0] : '0);
        end

        gpio_reg_update #(.W(W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr0    (pw0),
            .wdata0 (req0.wdata[W-1:0]),
            .wr1    (pw1),
            .wdata1 (req1.wdata[W-1:0]),
            .set_m  (smask),
            .clr_m  (cmask),
            .tog_m  (tmask),
            .q      (regs[g])
        );
    end

    assign pin_out = regs[0];
    assign pin_oe  = regs[1];

    // Select the readable word for one register index, zero-extended.
    function automatic logic [DATA_W-1:0] pick(input reg_idx_e idx);
        logic [DATA_W-1:0] v;
        v = '0;
        case (idx)
            RIDX_LVL:  v[W-1:0] = regs[0];
            RIDX_EN:   v[W-1:0] = regs[1];
            RIDX_PADS: v[W-1:0] = pads_sync;
            default:   v = '0;
        endcase
        return v;
    endfunction

    // Read selection for each port.
    always_comb begin
        rd_val0 = pick(req0.idx);
        rd_val1 = pick(req1.idx);
    end

    // R1: the cycle after reset every pin is high impedance with level low.
    a_r1_reset_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0 && pin_out == '0));

endmodule

// File: rtl/gpio_dual_port.sv
// Top: decodes two processor ports, feeds both banks and registers read data.
// Assumes ports never need back-pressure; every access completes in one cycle.
module gpio_dual_port
    import gpio_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               p0_wr_en,
    input  logic               p0_rd_en,
    input  logic [ADDR_W-1:0]  p0_addr,
    input  logic [DATA_W-1:0]  p0_wdata,
    output logic [DATA_W-1:0]  p0_rdata,
    input  logic               p1_wr_en,
    input  logic               p1_rd_en,
    input  logic [ADDR_W-1:0]  p1_addr,
    input  logic [DATA_W-1:0]  p1_wdata,
    output logic [DATA_W-1:0]  p1_rdata,
    output logic [USER_W-1:0]  user_out,
    output logic [USER_W-1:0]  user_oe,
    input  logic [USER_W-1:0]  user_in,
    output logic [FLASH_W-1:0] flash_out,
    output logic [FLASH_W-1:0] flash_oe,
    input  logic [FLASH_W-1:0] flash_in
);
    port_req_t         req0, req1;
    logic [DATA_W-1:0] u_rd0, u_rd1, f_rd0, f_rd1;

    // Decode both ports.
    always_comb begin
        req0 = decode_access(p0_wr_en, p0_rd_en, p0_addr, p0_wdata);
        req1 = decode_access(p1_wr_en, p1_rd_en, p1_addr, p1_wdata);
    end

    gpio_bank #(.W(USER_W), .BANK_ID(1'b0)) u_user (
        .clk     (clk),
        .rst_n   (rst_n),
        .req0    (req0),
        .req1    (req1),
        .pad_in  (user_in),
        .pin_out (user_out),
        .pin_oe  (user_oe),
        .rd_val0 (u_rd0),
        .rd_val1 (u_rd1)
    );

    gpio_bank #(.W(FLASH_W), .BANK_ID(1'b1)) u_flash (
        .clk     (clk),
        .rst_n   (rst_n),
        .req0    (req0),
        .req1    (req1),
        .pad_in  (flash_in),
        .pin_out (flash_out),
        .pin_oe  (flash_oe),
        .rd_val0 (f_rd0),
        .rd_val1 (f_rd1)
    );

    // Capture port 0 read data on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)          p0_rdata <= '0;
        else if (req0.rd_en) p0_rdata <= !req0.hit ? '0 : (req0.bank ? f_rd0 : u_rd0);
    end

    // Capture port 1 read data on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)          p1_rdata <= '0;
        else if (req1.rd_en) p1_rdata <= !req1.hit ? '0 : (req1.bank ? f_rd1 : u_rd1);
    end

    // R6: unmapped reads return zero on both ports.
    a_r6_unmapped_zero_p0: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd_en && !req0.hit) |=> (p0_rdata == '0));
    a_r6_unmapped_zero_p1: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_rd_en && !req1.hit) |=> (p1_rdata == '0));

    // R6: alias reads return zero.
    a_r6_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd_en && req0.hit && req0.idx != RIDX_LVL && req0.idx != RIDX_EN
         && req0.idx != RIDX_PADS) |=> (p0_rdata == '0));

    // R10: read data only moves on a read request.
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_rd_en |=> $stable(p1_rdata));

endmodule

// File: tb/gpio_dual_port_test.sv
module gpio_dual_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        p0_wr_en, p0_rd_en, p1_wr_en, p1_rd_en;
    logic [7:0]  p0_addr, p1_addr;
    logic [31:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;
    logic [29:0] user_out, user_oe, user_in;
    logic [5:0]  flash_out, flash_oe, flash_in;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_dual_port uut (
        .clk(clk), .rst_n(rst_n),
        .p0_wr_en(p0_wr_en), .p0_rd_en(p0_rd_en), .p0_addr(p0_addr),
        .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_wr_en(p1_wr_en), .p1_rd_en(p1_rd_en), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .user_out(user_out), .user_oe(user_oe), .user_in(user_in),
        .flash_out(flash_out), .flash_oe(flash_oe), .flash_in(flash_in)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of accesses at a falling edge; returns at the next falling edge.
    task automatic access(input logic w0, input logic r0, input logic [7:0] a0,
                          input logic [31:0] d0, input logic w1, input logic r1,
                          input logic [7:0] a1, input logic [31:0] d1);
        p0_wr_en = w0; p0_rd_en = r0; p0_addr = a0; p0_wdata = d0;
        p1_wr_en = w1; p1_rd_en = r1; p1_addr = a1; p1_wdata = d1;
        @(negedge clk);
        p0_wr_en = 0; p0_rd_en = 0; p1_wr_en = 0; p1_rd_en = 0;
    endtask

    function automatic logic [7:0] addr_of(input int bk, input int idx);
        return 8'(bk * 64 + idx * 4);
    endfunction

    function automatic logic [31:0] mask_of(input int bk);
        return (bk != 0) ? 32'h0000_003F : 32'h3FFF_FFFF;
    endfunction

    // Model: op 0 idle, 1 plain, 2 set, 3 clear, 4 toggle.
    function automatic logic [31:0] merge(input logic [31:0] cur, input int o0,
            input logic [31:0] d0, input int o1, input logic [31:0] d1, input logic [31:0] m);
        logic [31:0] b, s, c, t;
        b = cur;
        if (o1 == 1) b = d1;
        if (o0 == 1) b = d0;
        c = ((o0 == 3) ? d0 : 32'h0) | ((o1 == 3) ? d1 : 32'h0);
        s = ((o0 == 2) ? d0 : 32'h0) | ((o1 == 2) ? d1 : 32'h0);
        t = ((o0 == 4) ? d0 : 32'h0) | ((o1 == 4) ? d1 : 32'h0);
        return (((b & ~c) | s) ^ t) & m;
    endfunction

    function automatic string tag_of(input int o0, input int o1);
        if (o0 != 0 && o1 != 0) return "R8";
        case (o0 + o1)
            2:       return "R3";
            3:       return "R4";
            4:       return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    logic [31:0] model [2][2];

    initial begin
        int it = 0;
        rst_n = 0;
        p0_wr_en = 0; p0_rd_en = 0; p0_addr = 0; p0_wdata = 0;
        p1_wr_en = 0; p1_rd_en = 0; p1_addr = 0; p1_wdata = 0;
        user_in = '0; flash_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held.
        check("R1 user_oe", 32'(user_oe), 0);
        check("R1 user_out", 32'(user_out), 0);
        check("R1 flash_oe", 32'(flash_oe), 0);
        check("R1 p0_rdata", p0_rdata, 0);
        rst_n = 1;
        @(negedge clk);
        for (int b = 0; b < 2; b++) for (int r = 0; r < 2; r++) model[b][r] = 0;

        // R2..R5, R8, R9, R10, R6: sweep of all op pairs.
        for (int bk = 0; bk < 2; bk++)
            for (int rg = 0; rg < 2; rg++)
                for (int o0 = 0; o0 < 5; o0++)
                    for (int o1 = 0; o1 < 5; o1++) begin
                        logic [31:0] init, d0, d1;
                        int i0, i1;
                        it++;
                        init = 32'hC2B2AE35 * (it + 7);
                        d0   = 32'h9E3779B9 * (it + 1);
                        d1   = 32'h7F4A7C15 * (it + 3);
                        access(1, 0, addr_of(bk, rg * 4), init, 0, 0, 0, 0);
                        model[bk][rg] = init & mask_of(bk);
                        i0 = rg * 4 + ((o0 == 0) ? 0 : o0 - 1);
                        i1 = rg * 4 + ((o1 == 0) ? 0 : o1 - 1);
                        access(o0 != 0, 0, addr_of(bk, i0), d0, o1 != 0, 0, addr_of(bk, i1), d1);
                        model[bk][rg] = merge(model[bk][rg], o0, d0, o1, d1, mask_of(bk));
                        if (bk == 0) begin
                            check({tag_of(o0, o1), " user_out"}, 32'(user_out), model[0][0]);
                            check({tag_of(o0, o1), " user_oe"}, 32'(user_oe), model[0][1]);
                        end else begin
                            check("R9 flash_out", 32'(flash_out), model[1][0]);
                            check("R9 flash_oe", 32'(flash_oe), model[1][1]);
                        end
                        // R10: port 0 reads an alias, port 1 reads the plain register.
                        access(0, 1, addr_of(bk, rg * 4 + 1 + (it % 3)), 0,
                               0, 1, addr_of(bk, rg * 4), 0);
                        check("R6 alias read", p0_rdata, 0);
                        check({tag_of(o0, o1), " readback"}, p1_rdata, model[bk][rg]);
                    end

        // R2: upper data bits ignored.
        access(1, 0, addr_of(0, 0), 32'hFFFF_FFFF, 1, 0, addr_of(1, 4), 32'hFFFF_FFFF);
        access(0, 1, addr_of(0, 0), 0, 0, 1, addr_of(1, 4), 0);
        check("R2 user width", p0_rdata, 32'h3FFF_FFFF);
        check("R2 flash width", p1_rdata, 32'h0000_003F);

        // R6: unmapped addresses read zero and write nothing.
        access(1, 1, 8'h24, 32'h0, 1, 1, 8'h80, 32'h0);
        check("R6 word9 read", p0_rdata, 0);
        check("R6 bit7 read", p1_rdata, 0);
        check("R6 no pin change", 32'(user_out), 32'h3FFF_FFFF);
        access(0, 1, 8'h01, 0, 0, 0, 0, 0);
        check("R6 misaligned read", p0_rdata, 0);

        // R11: read in the same cycle as a write returns the old value.
        access(1, 0, addr_of(0, 0), 32'h0000_1234, 0, 1, addr_of(0, 0), 0);
        check("R11 read before write", p1_rdata, 32'h3FFF_FFFF);
        check("R11 pins after write", 32'(user_out), 32'h0000_1234);

        // R7: synchronizer delay on a walking-one across the user bank.
        for (int b = 0; b < 30; b++) begin
            logic [31:0] prev;
            prev = (b == 0) ? 32'h0 : (32'h1 << (b - 1));
            user_in = 30'(32'h1 << b);
            flash_in = 6'(32'h1 << (b % 6));
            access(0, 1, addr_of(0, 8), 0, 0, 0, 0, 0);
            check("R7 too early", p0_rdata, prev);
            access(0, 0, 0, 0, 0, 0, 0, 0);
            access(0, 1, addr_of(0, 8), 0, 0, 1, addr_of(1, 8), 0);
            check("R7 user pads", p0_rdata, 32'h1 << b);
            check("R9 flash pads", p1_rdata, 32'h1 << (b % 6));
        end

        done = 1;
        finish_run();
    end
endmodule